// File: doc/BRIEF.md
# DMA Channel Pause and Disable Handshake

This block sits between software and the data mover of one DMA channel and owns the channel's pause state. Software sets a pause request bit in the control word. The block then stalls the mover so that no new beat can start. Once the mover reports that no beat is in flight, the block raises a read-only acknowledge bit, and software polls for it. Clearing the request removes the stall, and the acknowledge drops one cycle later.

Turning the channel off uses the same handshake. When software writes the enable bit low while the channel runs, the enable is not cleared at once. The block forces an internal pause, waits for the acknowledge, and only then drops the enable. Peripheral requests that arrive while the channel is stalled are counted and kept. When the stall lifts, they are offered to the mover one at a time. Requests that arrive while the channel is off are discarded.

Top module: `dma_chan_pause_ctl`

## Requirements
- R1: After reset, chan_en, stall, paused, xfer_req and nowait are 0, and reads of byte offsets 0x00 and 0x08 return 0.
- R2: The control word is at byte offset 0x00. Bit 0 is the pause request and can be read and written. Bit 2 is the pause acknowledge, and writes to it have no effect. All other bits read 0.
- R3: The config word is at byte offset 0x08. Bit 0 is the channel enable. Bit 24 is the "skip block-done wait" flag, which is driven on the nowait port. Both bits read back.
- R4: stall goes high in the cycle after the pause request is written. paused rises only at a clock edge where stall is high and beat_busy is low. If the mover is idle, paused rises one cycle after stall.
- R5: Once stall is low, paused is low one cycle later. Clearing the pause request removes stall in the cycle after the write.
- R6: Writing the enable bit low while the channel is enabled raises stall. chan_en and the readable enable bit stay 1 until paused has been seen high, and they fall on the next edge.
- R7: Writes to the enable bit have no effect while a disable sequence is in progress.
- R8: Each req_in pulse while enabled adds one pending request, up to a limit of 2^PEND_W-1. xfer_req is high when the channel is enabled, not stalled, and has a pending request. A req_taken while xfer_req is high removes one. Requests are held, not dropped, while stalled.
- R9: req_in pulses while the channel is disabled are dropped. The pending count is cleared when the enable falls.
- R10: Writes to any offset other than 0x00 and 0x08 change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data at addr |
| beat_busy | input | 1 | Mover has a beat in flight |
| req_in | input | 1 | Peripheral transfer request pulse |
| req_taken | input | 1 | Mover accepts the offered request |
| xfer_req | output | 1 | A request is offered to the mover |
| stall | output | 1 | Mover must not start a new beat |
| paused | output | 1 | Pause acknowledge |
| chan_en | output | 1 | Channel enable |
| nowait | output | 1 | Skip block-done wait flag |

## Verification
The hardest state to reach is a disable sequence that is held open by a long beat, with a second enable write landing in the middle of it. With no beat in flight, the sequence finishes in two cycles and leaves no gap for that write. The stimulus therefore holds beat_busy high across both config writes, checks that the channel is still enabled and stalled but not acknowledged, and only then releases the beat. Saturation of the pending count is reached by pausing first and then issuing more requests than the count can hold.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int unsigned CTRL_OFS   = 0;
  localparam int unsigned CFG_OFS    = 8;
  localparam int unsigned REQ_BIT    = 0;
  localparam int unsigned ACK_BIT    = 2;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned NOWAIT_BIT = 24;

  function automatic logic [31:0] pack_ctrl(input logic req, input logic ack);
    logic [31:0] w;
    w = '0;
    w[REQ_BIT] = req;
    w[ACK_BIT] = ack;
    return w;
  endfunction

  function automatic logic [31:0] pack_cfg(input logic en, input logic nw);
    logic [31:0] w;
    w = '0;
    w[EN_BIT]     = en;
    w[NOWAIT_BIT] = nw;
    return w;
  endfunction
endpackage

// File: rtl/dcp_regs.sv
module dcp_regs #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wd_req,
  input  logic              wd_en,
  input  logic              wd_nowait,
  input  logic              ack,
  output logic              sw_pause,
  output logic              chan_en,
  output logic              nowait,
  output logic              disabling
);
  import dcp_pkg::*;

  logic wr_ctrl, wr_cfg;
  assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_OFS));
  assign wr_cfg  = wr_en && (addr == ADDR_W'(CFG_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pause  <= 1'b0;
      chan_en   <= 1'b0;
      nowait    <= 1'b0;
      disabling <= 1'b0;
    end else begin
      if (wr_ctrl) sw_pause <= wd_req;
      if (wr_cfg)  nowait   <= wd_nowait;
      if (disabling) begin
        if (ack) begin
          chan_en   <= 1'b0;
          disabling <= 1'b0;
        end
      end else if (wr_cfg) begin
        if (chan_en && !wd_en)      disabling <= 1'b1;
        else if (!chan_en && wd_en) chan_en   <= 1'b1;
      end
    end
  end

  // R6: enable only falls after the acknowledge was seen
  assert_en_fall_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chan_en) |-> $past(ack));
  // R6, R7: while disabling without ack the enable holds
  assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disabling && !ack) |=> chan_en);
endmodule

// File: rtl/dcp_ack.sv
module dcp_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic pause_eff,
  input  logic beat_busy,
  output logic ack
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack <= 1'b0;
    else        ack <= pause_eff && (ack || !beat_busy);
  end

  // R4: acknowledge rises only at a beat boundary while stalled
  assert_ack_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> $past(pause_eff && !beat_busy));
  // R4: idle mover gives acknowledge on the next cycle
  assert_ack_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_eff && !beat_busy) |=> ack);
  // R5: acknowledge drops one cycle after the stall is removed
  assert_ack_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_eff |=> !ack);
endmodule

// File: rtl/dcp_pend.sv
module dcp_pend #(
  parameter int PEND_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic stall,
  input  logic req_in,
  input  logic req_taken,
  output logic xfer_req
);
  localparam logic [PEND_W-1:0] CNT_MAX = {PEND_W{1'b1}};

  logic [PEND_W-1:0] cnt;
  logic inc, dec;

  function automatic logic [PEND_W-1:0] step_cnt(input logic [PEND_W-1:0] c,
                                                 input logic up, input logic dn);
    logic [PEND_W-1:0] r;
    r = c;
    if (up && !dn && c != CNT_MAX)  r = c + 1'b1;
    else if (dn && !up)             r = c - 1'b1;
    return r;
  endfunction

  assign xfer_req = chan_en && !stall && (cnt != '0);
  assign inc      = chan_en && req_in;
  assign dec      = req_taken && xfer_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!chan_en) cnt <= '0;
    else               cnt <= step_cnt(cnt, inc, dec);
  end

  // R8: an accepted request is still offered next cycle unless stalled or disabled
  assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && req_in) |=> (xfer_req || stall || !chan_en));
  // R9: nothing is offered just after the channel was off
  assert_no_req_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !xfer_req);
endmodule

// File: rtl/dma_chan_pause_ctl.sv
module dma_chan_pause_ctl #(
  parameter int ADDR_W = 6,
  parameter int PEND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              beat_busy,
  input  logic              req_in,
  input  logic              req_taken,
  output logic              xfer_req,
  output logic              stall,
  output logic              paused,
  output logic              chan_en,
  output logic              nowait
);
  import dcp_pkg::*;

  logic sw_pause, disabling, pause_eff;
  logic unused_wd;

  assign unused_wd = ^wr_data;

  dcp_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wd_req(wr_data[REQ_BIT]), .wd_en(wr_data[EN_BIT]),
    .wd_nowait(wr_data[NOWAIT_BIT]), .ack(paused),
    .sw_pause(sw_pause), .chan_en(chan_en), .nowait(nowait),
    .disabling(disabling)
  );

  assign pause_eff = sw_pause || disabling;
  assign stall     = pause_eff;

  dcp_ack ack_i (
    .clk(clk), .rst_n(rst_n), .pause_eff(pause_eff),
    .beat_busy(beat_busy), .ack(paused)
  );

  dcp_pend #(.PEND_W(PEND_W)) pend_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .stall(stall),
    .req_in(req_in), .req_taken(req_taken), .xfer_req(xfer_req)
  );

  always_comb begin
    if (addr == ADDR_W'(CTRL_OFS))     rd_data = pack_ctrl(sw_pause, paused);
    else if (addr == ADDR_W'(CFG_OFS)) rd_data = pack_cfg(chan_en, nowait);
    else                               rd_data = '0;
  end
endmodule

// File: tb/dma_chan_pause_ctl_tb_top.sv
module dma_chan_pause_ctl_tb_top;
  localparam int PEND_W = 2;
  localparam int NV = 19;
  // fields: busy wr cfg dpause den req take | exp {paused stall en xreq}
  localparam logic [10:0] VEC [NV] = '{
    11'b0_1_1_0_1_0_0_0010, 11'b0_0_0_0_0_1_0_0011, 11'b1_0_0_0_0_0_1_0010,
    11'b1_1_0_1_0_0_0_0110, 11'b1_0_0_0_0_1_0_0110, 11'b0_0_0_0_0_0_0_1110,
    11'b0_0_0_0_0_0_0_1110, 11'b0_1_0_0_0_0_0_1011, 11'b1_0_0_0_0_0_1_0010,
    11'b1_1_1_0_0_0_0_0110, 11'b0_0_0_0_0_0_0_1110, 11'b0_0_0_0_0_0_0_1000,
    11'b0_0_0_0_0_0_0_0000, 11'b0_0_0_0_0_1_0_0000, 11'b0_1_1_0_1_0_0_0010,
    11'b0_1_0_1_0_0_0_0110, 11'b0_0_0_0_0_0_0_1110, 11'b0_1_0_0_0_0_0_1010,
    11'b0_0_0_0_0_0_0_0010};

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, beat_busy = 0, req_in = 0, req_taken = 0;
  logic [5:0] addr = '0;
  logic [31:0] wr_data = '0, rd_data, rv;
  logic xfer_req, stall, paused, chan_en, nowait;
  int n_chk = 0, n_bad = 0, got;

  always #5 clk = ~clk;

  dma_chan_pause_ctl #(.ADDR_W(6), .PEND_W(PEND_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .beat_busy(beat_busy), .req_in(req_in),
    .req_taken(req_taken), .xfer_req(xfer_req), .stall(stall),
    .paused(paused), .chan_en(chan_en), .nowait(nowait));

  function automatic string vec_tag(input int i);
    case (i)
      0, 14:          return "R3";
      1, 2, 4, 6, 8:  return "R8";
      3, 5, 15, 16:   return "R4";
      7, 17, 18:      return "R5";
      9, 10, 11, 12:  return "R6";
      default:        return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(posedge clk); #1; wr_en = 0; addr = '0; wr_data = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rd_data; addr = '0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req_in = 1;
    @(posedge clk); #1; req_in = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 en", chan_en, 0); chk("R1 stall", stall, 0);
    chk("R1 paused", paused, 0); chk("R1 xreq", xfer_req, 0);
    chk("R1 nowait", nowait, 0);
    rd(6'h00, rv); chk("R1 rd ctrl", rv, 0);
    rd(6'h08, rv); chk("R1 rd cfg", rv, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      beat_busy = VEC[i][10];
      wr_en     = VEC[i][9];
      addr      = VEC[i][8] ? 6'h08 : 6'h00;
      wr_data   = VEC[i][8] ? {31'b0, VEC[i][6]} : {31'b0, VEC[i][7]};
      req_in    = VEC[i][5];
      req_taken = VEC[i][4];
      @(posedge clk); #1;
      wr_en = 0; req_in = 0; req_taken = 0; beat_busy = 0; addr = '0;
      chk($sformatf("%s step %0d", vec_tag(i), i),
          {28'b0, paused, stall, chan_en, xfer_req}, {28'b0, VEC[i][3:0]});
    end

    // R2: acknowledge bit is read-only
    wr(6'h00, 32'h4); cyc();
    rd(6'h00, rv); chk("R2 ack write ignored", rv, 0);
    chk("R2 no stall", stall, 0);
    wr(6'h00, 32'h1); cyc();
    rd(6'h00, rv); chk("R2 req and ack read", rv, 32'h5);
    wr(6'h00, 32'h0); cyc();

    // R3: no-wait flag and enable read back
    wr(6'h08, 32'h0100_0001);
    chk("R3 nowait port", nowait, 1);
    rd(6'h08, rv); chk("R3 cfg read", rv, 32'h0100_0001);

    // R10: unmapped offset
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, rv); chk("R10 unmapped read", rv, 0);
    rd(6'h00, rv); chk("R10 ctrl untouched", rv, 0);
    rd(6'h08, rv); chk("R10 cfg untouched", rv, 32'h0100_0001);

    // R7: enable write during a disable held open by a long beat
    beat_busy = 1;
    wr(6'h08, 32'h0);
    wr(6'h08, 32'h1);
    cyc(); cyc();
    chk("R7 en held", chan_en, 1); chk("R7 stalled", stall, 1);
    chk("R7 no ack while busy", paused, 0);
    beat_busy = 0;
    cyc(); cyc(); cyc();
    chk("R7 ends disabled", chan_en, 0); chk("R7 stall released", stall, 0);

    // R8: saturation of held requests
    wr(6'h08, 32'h1);
    wr(6'h00, 32'h1); cyc();
    chk("R8 paused", paused, 1);
    for (int k = 0; k < 5; k++) pulse_req();
    chk("R8 held while paused", xfer_req, 0);
    wr(6'h00, 32'h0);
    got = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      req_taken = xfer_req;
      if (xfer_req) got++;
      @(posedge clk); #1; req_taken = 0;
    end
    chk("R8 saturated count", got, (1 << PEND_W) - 1);

    // R9: pending cleared when enable falls
    pulse_req(); pulse_req();
    chk("R9 offered before disable", xfer_req, 1);
    wr(6'h08, 32'h0);
    cyc(); cyc(); cyc();
    chk("R9 disabled", chan_en, 0);
    wr(6'h08, 32'h1);
    chk("R9 pending cleared", xfer_req, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule